// File: doc/BRIEF.md
# Boot-Time Clock Configuration Sequencer

This block brings the board's clock tree into a usable state before any fabric clock exists. It runs only from an always-present auxiliary clock. Once that clock's valid flag is seen, it works out which plug-in clock module is fitted: none, a module carrying an external PLL, or a passive input module. It then reads the module's two configuration switches and picks one of seven register-write configurations. Those writes are streamed over SPI to the sampling clock buffer. One configuration also writes the RF reference clock buffer.

With the PLL module selected, the sequencer holds its writes until the PLL's reference clock is seen toggling. After the writes it waits for the PLL to report lock. Only at that point does it drop `clocks_invalid`, which holds the downstream clock managers and the rest of the design in reset. The sequencer then stops for good. Register values live in a small computed table and are placeholders.

Top module: `bootclk_seq`

## Requirements
- R1: After reset `clocks_invalid` is 1 and both chip selects are high. While `aux_clk_ok` stays low, no SPI frame is sent and `clocks_invalid` stays 1.
- R2: With neither module fitted, the no-module configuration is written and `clocks_invalid` falls without regard to `pll_ref_clk` or `pll_locked`.
- R3: The passive module (`inmod_fitted`) takes precedence over the PLL module. Its switch code `mod_sw` 00 selects the no-module configuration, 01 selects A, 10 selects B and 11 selects C, and the sequence completes without waiting on the PLL.
- R4: With only the PLL module fitted and `mod_sw`=00, the no-module configuration is written and the sequence completes without waiting for the reference clock or for lock.
- R5: With the PLL module and a nonzero code, no frame is sent until the reference clock is qualified. Qualification needs 8 rising edges of `pll_ref_clk` inside one window of 256 auxiliary cycles, and the edge count restarts at each window end. A reference slower than that never qualifies.
- R6: In PLL configurations A, B and C (codes 01, 10, 11), `clocks_invalid` stays 1 after the last frame until `pll_locked` is seen high. It then falls within a few cycles.
- R7: Each write is a 24-bit SPI mode-0 frame sent MSB first. Chip select stays low for the whole frame, `spi_sclk` idles low and has a period of 8 auxiliary cycles, and the data line is stable while `spi_sclk` is high.
- R8: Every configuration writes these sampling-buffer frames, as {16-bit instruction with bit 15 = 0 for write, 8-bit data}, in this order: source select 0x0045 (data 0x02 on-board for no-module and passive A, otherwise 0x01), output format 0x003D/0x08 (LVDS), divider 0x004A/0x80 (bypass), commit 0x005A/0x01.
- R9: Only PLL configuration A writes the RF reference buffer: one frame 0x004B/0x07, sent before any sampling-buffer frame. No other configuration drives `rref_cs_n` low.
- R10: Each PLL configuration precedes the source select with a reference-rate frame 0x0050. Its data is 0x0A (10 MHz) for A and B and 0x50 (80 MHz) for C.
- R11: The switches are sampled once, as the sequencer leaves idle. A later change on `mod_sw` has no effect on the frames sent.
- R12: Once `clocks_invalid` has fallen it stays 0 and no further frame is sent, even if `pll_locked` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aux_clk | input | 1 | Always-running auxiliary clock |
| aux_rst_n | input | 1 | Asynchronous active-low reset |
| aux_clk_ok | input | 1 | Auxiliary clock valid flag; the sequence starts once it is high |
| pllmod_fitted | input | 1 | PLL clock module present |
| inmod_fitted | input | 1 | Passive input clock module present |
| mod_sw | input | 2 | Module configuration switches |
| pll_ref_clk | input | 1 | PLL reference clock, asynchronous |
| pll_locked | input | 1 | PLL lock status, asynchronous |
| spi_sclk | output | 1 | Shared SPI clock |
| samp_cs_n | output | 1 | Sampling buffer chip select, active low |
| samp_mosi | output | 1 | Sampling buffer serial data |
| rref_cs_n | output | 1 | RF reference buffer chip select, active low |
| rref_mosi | output | 1 | RF reference buffer serial data |
| clocks_invalid | output | 1 | Reset hold for downstream clock logic, high until done |

## Verification
A wrong decode of module type or switches shows at the ports within one frame time, about 200 auxiliary cycles: either the first frame carries the wrong address or data, or the RF reference chip select moves when it should not. A broken wait on the reference clock or on lock shows as frames appearing while the reference is slow, or as `clocks_invalid` falling before lock. A broken halt shows as a chip select falling again, or `clocks_invalid` rising, after completion. The bench captures every frame bit by bit on the SPI pins and compares the frames with the tables given in the requirements.

// File: rtl/bootclk_pkg.sv
package bootclk_pkg;

  typedef enum logic [2:0] {
    CFG_NOMOD, CFG_PLL_A, CFG_PLL_B, CFG_PLL_C, CFG_PAS_A, CFG_PAS_B, CFG_PAS_C
  } cfg_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_WREF, ST_LOAD, ST_WSPI, ST_WLOCK, ST_DONE
  } st_e;

  localparam int unsigned STEPS   = 6;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = INSTR_W + DATA_W;

  typedef struct packed {
    logic               vld;
    logic               to_rref;
    logic [INSTR_W-1:0] instr;
    logic [DATA_W-1:0]  data;
  } wr_t;

  // Placeholder write table: every step is either used or skipped by a configuration
  function automatic wr_t rom_entry(cfg_e c, logic [2:0] step);
    wr_t  w;
    logic pll_m;
    logic onboard;
    pll_m   = (c == CFG_PLL_A) || (c == CFG_PLL_B) || (c == CFG_PLL_C);
    onboard = (c == CFG_NOMOD) || (c == CFG_PAS_A);
    w = '0;
    case (step)
      3'd0: begin
        w.vld = (c == CFG_PLL_A); w.to_rref = 1'b1;
        w.instr = 16'h004B; w.data = 8'h07;
      end
      3'd1: begin
        w.vld = pll_m; w.instr = 16'h0050;
        w.data = (c == CFG_PLL_C) ? 8'h50 : 8'h0A;
      end
      3'd2: begin
        w.vld = 1'b1; w.instr = 16'h0045;
        w.data = onboard ? 8'h02 : 8'h01;
      end
      3'd3: begin w.vld = 1'b1; w.instr = 16'h003D; w.data = 8'h08; end
      3'd4: begin w.vld = 1'b1; w.instr = 16'h004A; w.data = 8'h80; end
      3'd5: begin w.vld = 1'b1; w.instr = 16'h005A; w.data = 8'h01; end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/bootclk_sync.sv
module bootclk_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bootclk_refdet.sv
module bootclk_refdet #(
  parameter int unsigned EDGES  = 8,
  parameter int unsigned WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic toggling
);
  localparam int unsigned EW = $clog2(EDGES + 1);
  localparam int unsigned WW = $clog2(WINDOW);

  logic [2:0]    smp_q;
  logic [WW-1:0] win_q, win_n;
  logic [EW-1:0] edg_q, edg_n;
  logic          tog_q, tog_n;
  logic          rise;
  logic          win_end;

  assign rise    = smp_q[1] & ~smp_q[2];
  assign win_end = (win_q == WW'(WINDOW - 1));

  always_comb begin
    win_n = win_q;
    edg_n = edg_q;
    tog_n = tog_q;
    if (!tog_q) begin
      win_n = win_end ? '0 : win_q + 1'b1;
      if (rise) edg_n = edg_q + 1'b1;
      if (rise && (edg_q == EW'(EDGES - 1))) tog_n = 1'b1;
      else if (win_end) edg_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      win_q <= '0;
      edg_q <= '0;
      tog_q <= 1'b0;
    end else begin
      smp_q <= {smp_q[1:0], ref_in};
      win_q <= win_n;
      edg_q <= edg_n;
      tog_q <= tog_n;
    end
  end

  assign toggling = tog_q;
endmodule

// File: rtl/bootclk_spi_tx.sv
module bootclk_spi_tx #(
  parameter int unsigned FRAME = 24,
  parameter int unsigned DIV   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             to_rref,
  input  logic [FRAME-1:0] frame,
  output logic             sclk,
  output logic             samp_cs_n,
  output logic             samp_mosi,
  output logic             rref_cs_n,
  output logic             rref_mosi,
  output logic             done
);
  localparam int unsigned DW = $clog2(DIV);
  localparam int unsigned BW = $clog2(FRAME);

  logic             busy_q, busy_n;
  logic             tgt_q, tgt_n;
  logic [FRAME-1:0] sh_q, sh_n;
  logic [BW-1:0]    bit_q, bit_n;
  logic [DW-1:0]    div_q, div_n;
  logic             done_q, done_n;

  always_comb begin
    busy_n = busy_q;
    tgt_n  = tgt_q;
    sh_n   = sh_q;
    bit_n  = bit_q;
    div_n  = div_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        tgt_n  = to_rref;
        sh_n   = frame;
        bit_n  = '0;
        div_n  = '0;
      end
    end else begin
      div_n = div_q + 1'b1;
      if (div_q == DW'(DIV - 1)) begin
        div_n = '0;
        if (bit_q == BW'(FRAME - 1)) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          bit_n = bit_q + 1'b1;
          sh_n  = {sh_q[FRAME-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgt_q  <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      tgt_q  <= tgt_n;
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      div_q  <= div_n;
      done_q <= done_n;
    end
  end

  assign sclk      = busy_q & div_q[DW-1];
  assign samp_cs_n = ~(busy_q & ~tgt_q);
  assign rref_cs_n = ~(busy_q & tgt_q);
  assign samp_mosi = busy_q & ~tgt_q & sh_q[FRAME-1];
  assign rref_mosi = busy_q & tgt_q & sh_q[FRAME-1];
  assign done      = done_q;
endmodule

// File: rtl/bootclk_seq.sv
module bootclk_seq
  import bootclk_pkg::*;
#(
  parameter int unsigned SPI_DIV    = 8,
  parameter int unsigned REF_EDGES  = 8,
  parameter int unsigned REF_WINDOW = 256
) (
  input  logic       aux_clk,
  input  logic       aux_rst_n,
  input  logic       aux_clk_ok,
  input  logic       pllmod_fitted,
  input  logic       inmod_fitted,
  input  logic [1:0] mod_sw,
  input  logic       pll_ref_clk,
  input  logic       pll_locked,
  output logic       spi_sclk,
  output logic       samp_cs_n,
  output logic       samp_mosi,
  output logic       rref_cs_n,
  output logic       rref_mosi,
  output logic       clocks_invalid
);
  localparam logic [2:0] LAST_STEP = 3'(STEPS - 1);

  logic [1:0] rs_q;
  logic       rst_n_s;
  logic [5:0] in_s;
  logic       ok_s, pllmod_s, inmod_s, lock_s;
  logic [1:0] sw_s;
  logic       ref_ok;

  st_e        st_q, st_n;
  cfg_e       cfg_q, cfg_n;
  logic       wlock_q, wl_n;
  logic [2:0] step_q, step_n;
  logic       inv_q, inv_n;
  logic       spi_go, spi_done;
  wr_t        ent;
  logic       last;

  // reset asserts at once, releases on the auxiliary clock
  always_ff @(posedge aux_clk or negedge aux_rst_n) begin
    if (!aux_rst_n) rs_q <= 2'b00;
    else            rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  bootclk_sync #(.W(6), .STAGES(2)) in_sync_i (
    .clk  (aux_clk),
    .rst_n(rst_n_s),
    .d    ({aux_clk_ok, pllmod_fitted, inmod_fitted, mod_sw, pll_locked}),
    .q    (in_s)
  );
  assign {ok_s, pllmod_s, inmod_s, sw_s, lock_s} = in_s;

  bootclk_refdet #(.EDGES(REF_EDGES), .WINDOW(REF_WINDOW)) refdet_i (
    .clk     (aux_clk),
    .rst_n   (rst_n_s),
    .ref_in  (pll_ref_clk),
    .toggling(ref_ok)
  );

  bootclk_spi_tx #(.FRAME(FRAME_W), .DIV(SPI_DIV)) spi_i (
    .clk      (aux_clk),
    .rst_n    (rst_n_s),
    .start    (spi_go),
    .to_rref  (ent.to_rref),
    .frame    ({ent.instr, ent.data}),
    .sclk     (spi_sclk),
    .samp_cs_n(samp_cs_n),
    .samp_mosi(samp_mosi),
    .rref_cs_n(rref_cs_n),
    .rref_mosi(rref_mosi),
    .done     (spi_done)
  );

  assign ent  = rom_entry(cfg_q, step_q);
  assign last = (step_q == LAST_STEP);

  always_comb begin
    st_n   = st_q;
    cfg_n  = cfg_q;
    wl_n   = wlock_q;
    step_n = step_q;
    inv_n  = inv_q;
    spi_go = 1'b0;
    case (st_q)
      ST_IDLE: if (ok_s) st_n = ST_PICK;
      ST_PICK: begin
        step_n = '0;
        if (inmod_s) begin
          wl_n = 1'b0;
          st_n = ST_LOAD;
          case (sw_s)
            2'b01:   cfg_n = CFG_PAS_A;
            2'b10:   cfg_n = CFG_PAS_B;
            2'b11:   cfg_n = CFG_PAS_C;
            default: cfg_n = CFG_NOMOD;
          endcase
        end else if (pllmod_s && (sw_s != 2'b00)) begin
          wl_n = 1'b1;
          st_n = ST_WREF;
          case (sw_s)
            2'b01:   cfg_n = CFG_PLL_A;
            2'b10:   cfg_n = CFG_PLL_B;
            default: cfg_n = CFG_PLL_C;
          endcase
        end else begin
          wl_n  = 1'b0;
          cfg_n = CFG_NOMOD;
          st_n  = ST_LOAD;
        end
      end
      ST_WREF: if (ref_ok) st_n = ST_LOAD;
      ST_LOAD: begin
        if (ent.vld) begin
          spi_go = 1'b1;
          st_n   = ST_WSPI;
        end else if (last) begin
          st_n = wlock_q ? ST_WLOCK : ST_DONE;
        end else begin
          step_n = step_q + 1'b1;
        end
      end
      ST_WSPI: begin
        if (spi_done) begin
          if (last) begin
            st_n = wlock_q ? ST_WLOCK : ST_DONE;
          end else begin
            step_n = step_q + 1'b1;
            st_n   = ST_LOAD;
          end
        end
      end
      ST_WLOCK: if (lock_s) st_n = ST_DONE;
      ST_DONE:  st_n = ST_DONE;
      default:  st_n = ST_IDLE;
    endcase
    if (st_n == ST_DONE) inv_n = 1'b0;
  end

  always_ff @(posedge aux_clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      cfg_q   <= CFG_NOMOD;
      wlock_q <= 1'b0;
      step_q  <= '0;
      inv_q   <= 1'b1;
    end else begin
      st_q    <= st_n;
      cfg_q   <= cfg_n;
      wlock_q <= wl_n;
      step_q  <= step_n;
      inv_q   <= inv_n;
    end
  end

  assign clocks_invalid = inv_q;
endmodule

// File: rtl/bootclk_seq_chk.sv
module bootclk_seq_chk
  import bootclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input st_e  st_q,
  input cfg_e cfg_q,
  input logic wlock_q,
  input logic lock_s,
  input logic ref_ok,
  input logic spi_sclk,
  input logic samp_cs_n,
  input logic samp_mosi,
  input logic rref_cs_n,
  input logic clocks_invalid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (samp_cs_n && rref_cs_n)); // R1

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !samp_cs_n && $past(!samp_cs_n)) |-> $stable(samp_mosi)); // R7

  AST_REF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WREF) |=> ((st_q == ST_WREF) || ref_ok)); // R5

  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clocks_invalid) && wlock_q) |-> $past(lock_s)); // R6

  AST_RREF_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
    !rref_cs_n |-> (cfg_q == CFG_PLL_A)); // R9

  AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !clocks_invalid |=> (!clocks_invalid && samp_cs_n && rref_cs_n)); // R12
endmodule

bind bootclk_seq bootclk_seq_chk chk_i (
  .clk           (aux_clk),
  .rst_n         (rst_n_s),
  .st_q          (st_q),
  .cfg_q         (cfg_q),
  .wlock_q       (wlock_q),
  .lock_s        (lock_s),
  .ref_ok        (ref_ok),
  .spi_sclk      (spi_sclk),
  .samp_cs_n     (samp_cs_n),
  .samp_mosi     (samp_mosi),
  .rref_cs_n     (rref_cs_n),
  .clocks_invalid(clocks_invalid)
);

// File: tb/bootclk_seq_tb_top.sv
`timescale 1ns/1ps
module bootclk_seq_tb_top;
  logic       aux_clk = 1'b0;
  logic       aux_rst_n;
  logic       aux_clk_ok;
  logic       pllmod_fitted;
  logic       inmod_fitted;
  logic [1:0] mod_sw;
  logic       pll_ref_clk = 1'b0;
  logic       pll_locked;
  logic       spi_sclk, samp_cs_n, samp_mosi, rref_cs_n, rref_mosi, clocks_invalid;

  int n_checks = 0;
  int n_fail   = 0;

  bit ref_run  = 1'b0;
  int ref_half = 20;

  logic [23:0] samp_log [16];
  logic [23:0] rref_log [4];
  int          samp_n, rref_n, bad_frames, rref_before;
  logic [23:0] samp_sh, rref_sh;
  int          samp_bits, rref_bits;
  realtime     t_prev, t_per;

  always #2 aux_clk = ~aux_clk;

  always begin
    if (ref_run) begin
      #(ref_half * 1ns);
      pll_ref_clk = ~pll_ref_clk;
    end else begin
      #10;
    end
  end

  bootclk_seq dut_i (
    .aux_clk(aux_clk), .aux_rst_n(aux_rst_n), .aux_clk_ok(aux_clk_ok),
    .pllmod_fitted(pllmod_fitted), .inmod_fitted(inmod_fitted), .mod_sw(mod_sw),
    .pll_ref_clk(pll_ref_clk), .pll_locked(pll_locked), .spi_sclk(spi_sclk),
    .samp_cs_n(samp_cs_n), .samp_mosi(samp_mosi), .rref_cs_n(rref_cs_n),
    .rref_mosi(rref_mosi), .clocks_invalid(clocks_invalid)
  );

  // frame capture on the SPI pins
  always @(negedge samp_cs_n) samp_bits = 0;
  always @(negedge rref_cs_n) rref_bits = 0;
  always @(posedge spi_sclk) begin
    t_per  = $realtime - t_prev;
    t_prev = $realtime;
    if (!samp_cs_n) begin samp_sh = {samp_sh[22:0], samp_mosi}; samp_bits++; end
    if (!rref_cs_n) begin rref_sh = {rref_sh[22:0], rref_mosi}; rref_bits++; end
  end
  always @(posedge samp_cs_n) if (samp_bits != 0) begin
    if (samp_bits != 24) bad_frames++;
    else if (samp_n < 16) samp_log[samp_n] = samp_sh;
    samp_n++;
    samp_bits = 0;
  end
  always @(posedge rref_cs_n) if (rref_bits != 0) begin
    if (rref_bits != 24) bad_frames++;
    else if (rref_n < 4) rref_log[rref_n] = rref_sh;
    if (rref_n == 0) rref_before = samp_n;
    rref_n++;
    rref_bits = 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge aux_clk);
    #1;
  endtask

  task automatic do_reset(input bit pll, input bit inm, input logic [1:0] sw);
    aux_rst_n = 1'b0; aux_clk_ok = 1'b0; pll_locked = 1'b0;
    pllmod_fitted = pll; inmod_fitted = inm; mod_sw = sw;
    wait_cyc(4);
    samp_n = 0; rref_n = 0; bad_frames = 0; rref_before = -1;
    samp_bits = 0; rref_bits = 0;
    aux_rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic wait_done(input int max, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      if (!clocks_invalid) begin ok = 1'b1; break; end
      wait_cyc(1);
    end
  endtask

  // cfg: 0 none, 1..3 PLL A..C, 4..6 passive A..C
  task automatic check_frames(input int cfg, input string req);
    logic [23:0] e [6];
    int ne;
    ne = 0;
    if (cfg >= 1 && cfg <= 3) begin
      e[ne] = {16'h0050, (cfg == 3) ? 8'h50 : 8'h0A}; ne++;
    end
    e[ne] = {16'h0045, (cfg == 0 || cfg == 4) ? 8'h02 : 8'h01}; ne++;
    e[ne] = {16'h003D, 8'h08}; ne++;
    e[ne] = {16'h004A, 8'h80}; ne++;
    e[ne] = {16'h005A, 8'h01}; ne++;
    chk(samp_n == ne, {req, " R8 frame count"}, samp_n, ne);
    chk(bad_frames == 0, {req, " R7 frame length"}, bad_frames, 0);
    for (int i = 0; i < ne && i < samp_n; i++)
      chk(samp_log[i] == e[i], {req, " R8 frame content"}, samp_log[i], e[i]);
    if (cfg == 1) begin
      chk(rref_n == 1 && rref_log[0] == 24'h004B07, "R9 RF buffer frame", rref_log[0], 24'h004B07);
      chk(rref_before == 0, "R9 RF frame first", rref_before, 0);
    end else begin
      chk(rref_n == 0, "R9 no RF buffer frame", rref_n, 0);
    end
  endtask

  task automatic t_reset_idle();
    do_reset(1'b0, 1'b0, 2'b00);
    chk(clocks_invalid === 1'b1, "R1 invalid after reset", clocks_invalid, 1);
    chk(samp_cs_n === 1'b1 && rref_cs_n === 1'b1, "R1 cs idle", {samp_cs_n, rref_cs_n}, 2'b11);
    wait_cyc(300);
    chk(samp_n == 0 && clocks_invalid, "R1 no start while clock not ok", samp_n, 0);
  endtask

  task automatic t_no_module();
    bit ok;
    do_reset(1'b0, 1'b0, 2'b11);
    aux_clk_ok = 1'b1;
    wait_done(5000, ok);
    chk(ok, "R2 completes without PLL", clocks_invalid, 0);
    check_frames(0, "R2");
    chk(t_per == 32.0, "R7 sclk period", longint'(t_per), 32);
  endtask

  task automatic t_passive();
    bit ok;
    for (int code = 0; code < 4; code++) begin
      do_reset(1'b1, 1'b1, code[1:0]);
      aux_clk_ok = 1'b1;
      wait_done(5000, ok);
      chk(ok, "R3 passive completes without lock", code, 0);
      check_frames(code == 0 ? 0 : 3 + code, "R3");
    end
  endtask

  task automatic t_pll_off();
    bit ok;
    ref_run = 1'b0;
    do_reset(1'b1, 1'b0, 2'b00);
    aux_clk_ok = 1'b1;
    wait_done(5000, ok);
    chk(ok, "R4 PLL code 00 no wait", clocks_invalid, 0);
    check_frames(0, "R4");
  endtask

  task automatic t_pll_a();
    bit ok;
    ref_half = 2000; ref_run = 1'b1;
    do_reset(1'b1, 1'b0, 2'b01);
    aux_clk_ok = 1'b1;
    wait_cyc(3000);
    chk(samp_n == 0 && rref_n == 0, "R5 slow ref blocks frames", samp_n + rref_n, 0);
    ref_half = 20;
    wait_cyc(3000);
    chk(clocks_invalid === 1'b1, "R6 held until lock", clocks_invalid, 1);
    check_frames(1, "R10");
    pll_locked = 1'b1;
    wait_cyc(6);
    chk(clocks_invalid === 1'b0, "R6 release after lock", clocks_invalid, 0);
    pll_locked = 1'b0;
    mod_sw = 2'b10;
    wait_cyc(500);
    chk(clocks_invalid === 1'b0 && samp_n == 5 && rref_n == 1, "R12 halted", samp_n, 5);
  endtask

  task automatic t_pll_bc();
    bit ok;
    ref_half = 20; ref_run = 1'b1;
    for (int code = 2; code < 4; code++) begin
      do_reset(1'b1, 1'b0, code[1:0]);
      pll_locked = 1'b1;
      aux_clk_ok = 1'b1;
      wait_done(5000, ok);
      chk(ok, "R6 completes with lock", code, 0);
      check_frames(code, "R10");
    end
  endtask

  task automatic t_sw_once();
    bit ok;
    do_reset(1'b0, 1'b1, 2'b01);
    aux_clk_ok = 1'b1;
    wait_cyc(20);
    mod_sw = 2'b11;
    wait_done(5000, ok);
    chk(ok, "R11 completes", clocks_invalid, 0);
    check_frames(4, "R11");
  endtask

  initial begin : wd
    #(600000 * 1ns);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_no_module();
    t_passive();
    t_pll_off();
    t_pll_a();
    t_pll_bc();
    t_sw_once();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule